// File: doc/BRIEF.md
# FIFO-Buffered I2C Master Engine

This block is a single-master I2C controller core. Software-side logic pushes 9-bit words into an 8-entry transmit FIFO. A word with bit 8 set is an address command. A word with bit 8 clear is a data byte. Received bytes come back through an 8-entry receive FIFO. A small control word starts and ends transfers. The engine turns the queued words into START, address, data, acknowledge and STOP phases on open-drain SCL and SDA lines.

A read can be bounded by a receive byte count. When the count is nonzero, the engine answers the last counted byte with NACK by itself. When the count is zero, a NACK control bit ends the read instead. A repeated START needs no control write. Pushing a new address command while the engine holds the bus is enough.

The SCL half period in core clock cycles comes from a separate timing block on the `half_cycles` input, and its value must be at least 2. Target clock stretching and slave mode are not supported. A lost arbitration is only reported.

Top module: `fifo_i2c_master`

## Requirements
- R1: After reset both line enables are low, `status` reads 13'h0003 (only transmit-not-full and transmit-empty set), and `events` is zero.
- R2: Each FIFO holds 8 words. On a first access the address command fills one transmit slot, which leaves 7 data slots. A push to a full transmit FIFO is ignored, so that word never reaches the bus.
- R3: A transmit word with bit 8 = 1 is an address command. Its bits 7:1 hold the 7-bit target address and bit 0 is 1 for read and 0 for write. Bytes go out MSB first. Each byte is followed by an acknowledge slot whose SDA level the engine samples on the rising edge of SCL.
- R4: The control word uses bit 3 for master enable, bit 2 for START, bit 1 for STOP and bit 0 for forced NACK. START and STOP are one-shot and act only when bit 3 is set in the same write. STOP is issued only once queued work is done, and its completion raises the stop event.
- R5: When the receive count is nonzero, the engine answers the last counted byte with NACK, raises the count-done event and stops receiving.
- R6: When the receive count is 0, reading continues until forced NACK (control bit 0) is set. The byte received under it gets a NACK and ends the read.
- R7: If an address command is pushed while the bus is held after a transfer with no STOP, the engine makes a repeated START and sends that address, with no START write.
- R8: When a target NACKs an address or data byte, the engine raises the NACK event and sends no further data from the FIFO. A pending STOP is still issued, and unsent words stay in the FIFO.
- R9: `rx_rdata` reads zero while the receive FIFO is empty. A pop of an empty FIFO is ignored.
- R10: `flush_tx` and `flush_rx` each empty their FIFO in one cycle. `bus_reset` returns the engine to idle with both lines released and drops any pending START or STOP.
- R11: `status` bit 12 is device busy, bit 11 is STOP detected (set on STOP, cleared on the next START), bit 8 is bus busy, bit 3 is receive full, bit 2 is receive not empty, bit 1 is transmit not full and bit 0 is transmit empty. All other bits read 0.
- R12: If SDA reads low during the address or data phase while the engine leaves it released, the arbitration-lost event is raised, both lines are released and the engine goes idle.
- R13: `events` carries one-cycle pulses: bit 0 for write held waiting with the transmit FIFO empty, bit 1 for receive FIFO became full, bit 2 for STOP done, bit 3 for count done, bit 4 for NACK and bit 5 for arbitration lost. While the bus is held between bytes, SCL is kept low.
- R14: During a data or acknowledge bit, SDA only changes while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: master, START, STOP, forced NACK |
| tx_we | input | 1 | Transmit FIFO push |
| tx_wdata | input | 9 | Transmit word: bit 8 command flag, bits 7:0 payload |
| rx_re | input | 1 | Receive FIFO pop |
| rx_rdata | output | 8 | Receive FIFO head, zero when empty |
| rbc_we | input | 1 | Receive byte count write strobe |
| rbc_wdata | input | 8 | Receive byte count, 0 disables counting |
| flush_tx | input | 1 | Empty the transmit FIFO |
| flush_rx | input | 1 | Empty the receive FIFO |
| bus_reset | input | 1 | Force the engine idle and release the lines |
| half_cycles | input | 16 | SCL half period in clock cycles, at least 2 |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status | output | 13 | Status flags |
| events | output | 6 | Event pulses to the interrupt unit |

## Verification
Several rules hold every cycle, and assertions check them. SDA stays stable while SCL is released during a bit. FIFO pops and pushes never hit an empty or full FIFO, and no FIFO count goes past its depth. SCL stays low whenever the bus is held. Both lines are released on arbitration loss and at STOP. Only the bench's scenarios, driven against a modelled target, can show the rest: the bytes seen on the bus, automatic NACK after a counted read, manual NACK, repeated START on a bare address push, halting after a target NACK, a full-FIFO push being dropped, and the flush and bus-reset effects at the ports.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = BYTE_W + 1;
    localparam int TIMER_W  = 16;
    localparam int STATUS_W = 13;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_HOLD, ST_RESTART, ST_LOW, ST_HIGH, ST_STOP
    } eng_state_t;

    typedef struct packed {
        logic arb_lost;
        logic nack;
        logic count_done;
        logic stop_done;
        logic rx_full;
        logic tx_wait;
    } evt_t;

    typedef struct packed {
        logic master;
        logic start;
        logic stop;
        logic nack;
    } ctrl_t;

    function automatic logic [STATUS_W-1:0] pack_status(
        logic dev_busy, logic stop_seen, logic bus_busy,
        logic rx_full, logic rx_nempty, logic tx_nfull, logic tx_empty);
        return {dev_busy, stop_seen, 2'b00, bus_busy, 4'b0000,
                rx_full, rx_nempty, tx_nfull, tx_empty};
    endfunction
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            if (do_push && !do_pop)      cnt <= cnt + CW'(1);
            else if (do_pop && !do_push) cnt <= cnt - CW'(1);
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_rst,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               nack_force,
    input  logic               rbc_we,
    input  logic [BYTE_W-1:0]  rbc_val,
    input  logic [TIMER_W-1:0] half_cycles,
    input  logic [WORD_W-1:0]  tx_head,
    input  logic               tx_empty,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [BYTE_W-1:0]  rx_data,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               dev_busy,
    output logic               bus_busy,
    output logic               stop_seen,
    output logic               ev_txw,
    output logic               ev_stop,
    output logic               ev_cnt,
    output logic               ev_nack,
    output logic               ev_arb
);
    eng_state_t         state;
    logic [1:0]         step;
    logic [TIMER_W-1:0] tmr;
    logic [BYTE_W-1:0]  sh, rbc_left;
    logic [3:0]         bitn;
    logic start_pend, stop_pend, fresh, halted, rd_mode, rd_done, manual, is_cmd, smp;
    logic txw_q;

    logic tick, take_cmd, take_wr, take_rd, go_stop, rcv_byte, nack_this, arb, txw_lvl;

    assign tick      = (tmr >= half_cycles);
    assign take_cmd  = (state == ST_HOLD) && !tx_empty && tx_head[BYTE_W];
    assign take_wr   = (state == ST_HOLD) && !take_cmd && !halted && !rd_mode && !tx_empty;
    assign take_rd   = (state == ST_HOLD) && !take_cmd && !halted && rd_mode && !rd_done
                       && !rx_full && (manual || rbc_left != '0);
    assign go_stop   = (state == ST_HOLD) && !take_cmd && !take_wr && !take_rd && stop_pend;
    assign tx_pop    = (take_cmd && fresh) || take_wr;
    assign rcv_byte  = rd_mode && !is_cmd;
    assign nack_this = rcv_byte && (nack_force || (!manual && rbc_left == BYTE_W'(1)));
    assign rx_push   = (state == ST_HIGH) && (tmr != '0) && tick && (bitn == 4'd8) && rcv_byte;
    assign rx_data   = sh;
    assign arb       = (state == ST_HIGH) && (tmr == '0) && !rcv_byte && (bitn != 4'd8)
                       && sh[BYTE_W-1] && !sda_in;
    assign txw_lvl   = (state == ST_HOLD) && !rd_mode && !halted && tx_empty && !stop_pend;
    assign ev_txw    = txw_lvl && !txw_q;
    assign dev_busy  = (state != ST_IDLE) || start_pend;
    assign bus_busy  = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            state <= ST_IDLE;  step <= '0;  tmr <= '0;  sh <= '0;  bitn <= '0;
            scl_oe <= 1'b0;  sda_oe <= 1'b0;  start_pend <= 1'b0;  stop_pend <= 1'b0;
            fresh <= 1'b0;  halted <= 1'b0;  rd_mode <= 1'b0;  rd_done <= 1'b0;
            is_cmd <= 1'b0;  smp <= 1'b1;  txw_q <= 1'b0;  stop_seen <= 1'b0;
            ev_stop <= 1'b0;  ev_cnt <= 1'b0;  ev_nack <= 1'b0;  ev_arb <= 1'b0;
            if (rst) begin
                rbc_left <= '0;
                manual   <= 1'b1;
            end
        end else begin
            ev_stop <= 1'b0;  ev_cnt <= 1'b0;  ev_nack <= 1'b0;  ev_arb <= 1'b0;
            txw_q   <= txw_lvl;
            if (start_req) start_pend <= 1'b1;
            if (stop_req)  stop_pend  <= 1'b1;
            if (rbc_we) begin
                rbc_left <= rbc_val;
                manual   <= (rbc_val == '0);
            end
            tmr <= (tick || state == ST_IDLE || state == ST_HOLD) ? '0 : tmr + TIMER_W'(1);
            case (state)
                ST_IDLE: begin
                    scl_oe <= 1'b0;
                    sda_oe <= 1'b0;
                    if (start_pend && !tx_empty && tx_head[BYTE_W]) begin
                        state      <= ST_START;
                        start_pend <= 1'b0;
                        sda_oe     <= 1'b1;
                        stop_seen  <= 1'b0;
                    end else if (!start_pend && !start_req) begin
                        stop_pend  <= 1'b0;
                    end
                end
                ST_START: if (tick) begin
                    scl_oe <= 1'b1;
                    fresh  <= 1'b1;
                    state  <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (take_cmd && fresh) begin
                        sh <= tx_head[BYTE_W-1:0];  is_cmd <= 1'b1;  rd_mode <= tx_head[0];
                        halted <= 1'b0;  rd_done <= 1'b0;  fresh <= 1'b0;
                        bitn <= '0;  state <= ST_LOW;
                    end else if (take_cmd) begin
                        sda_oe <= 1'b0;  step <= '0;  state <= ST_RESTART;
                    end else if (take_wr || take_rd) begin
                        sh <= take_wr ? tx_head[BYTE_W-1:0] : '0;
                        is_cmd <= 1'b0;  bitn <= '0;  state <= ST_LOW;
                    end else if (go_stop) begin
                        sda_oe <= 1'b1;  step <= '0;  state <= ST_STOP;
                    end
                end
                ST_RESTART: if (tick) begin
                    step <= step + 2'd1;
                    case (step)
                        2'd0:    scl_oe <= 1'b0;
                        2'd1:    sda_oe <= 1'b1;
                        default: begin scl_oe <= 1'b1; fresh <= 1'b1; state <= ST_HOLD; end
                    endcase
                end
                ST_LOW: begin
                    if (bitn == 4'd8) sda_oe <= rcv_byte ? !nack_this : 1'b0;
                    else              sda_oe <= rcv_byte ? 1'b0 : !sh[BYTE_W-1];
                    if (tick) begin
                        scl_oe <= 1'b0;
                        state  <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr == '0) begin
                        smp <= sda_in;
                        if (arb) begin
                            ev_arb <= 1'b1;  state <= ST_IDLE;  scl_oe <= 1'b0;  sda_oe <= 1'b0;
                            start_pend <= 1'b0;  stop_pend <= 1'b0;
                        end
                    end else if (tick) begin
                        scl_oe <= 1'b1;
                        if (bitn != 4'd8) begin
                            sh    <= {sh[BYTE_W-2:0], smp};
                            bitn  <= bitn + 4'd1;
                            state <= ST_LOW;
                        end else begin
                            state <= ST_HOLD;
                            if (!rcv_byte) begin
                                if (smp) begin ev_nack <= 1'b1; halted <= 1'b1; end
                            end else begin
                                if (!manual) rbc_left <= rbc_left - BYTE_W'(1);
                                if (nack_this) begin
                                    rd_done <= 1'b1;
                                    if (!manual) ev_cnt <= 1'b1;
                                end
                            end
                        end
                    end
                end
                ST_STOP: if (tick) begin
                    step <= step + 2'd1;
                    case (step)
                        2'd0:    scl_oe <= 1'b0;
                        2'd1:    sda_oe <= 1'b0;
                        default: begin
                            state <= ST_IDLE;  stop_seen <= 1'b1;  ev_stop <= 1'b1;
                            stop_pend <= 1'b0;  halted <= 1'b0;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R14
    sda_stable_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_oe));

    // R2
    tx_pop_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        tx_pop |-> !tx_empty);

    // R2
    rx_push_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        rx_push |-> !rx_full);

    // R12
    arb_release_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        ev_arb |-> (!scl_oe && !sda_oe && state == ST_IDLE));

    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        ev_stop |-> (!scl_oe && !sda_oe && stop_seen));

    // R13
    hold_scl_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (state == ST_HOLD) |-> scl_oe);

    // R5
    count_nack_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        ev_cnt |-> (rd_done && rbc_left == '0));
endmodule

// File: rtl/fifo_i2c_master.sv
module fifo_i2c_master
    import i2cm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_we,
    input  logic [3:0]          ctrl_wdata,
    input  logic                tx_we,
    input  logic [WORD_W-1:0]   tx_wdata,
    input  logic                rx_re,
    output logic [BYTE_W-1:0]   rx_rdata,
    input  logic                rbc_we,
    input  logic [BYTE_W-1:0]   rbc_wdata,
    input  logic                flush_tx,
    input  logic                flush_rx,
    input  logic                bus_reset,
    input  logic [TIMER_W-1:0]  half_cycles,
    input  logic                sda_in,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic [STATUS_W-1:0] status,
    output logic [5:0]          events
);
    localparam int FIFO_DEPTH = 8;

    ctrl_t             cw;
    evt_t              ev;
    logic              nack_q, rxf_q;
    logic [WORD_W-1:0] tx_head;
    logic              tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
    logic [BYTE_W-1:0] rx_data;
    logic              dev_busy, bus_busy, stop_seen;

    assign cw = ctrl_t'(ctrl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            nack_q <= 1'b0;
            rxf_q  <= 1'b0;
        end else begin
            if (ctrl_we) nack_q <= cw.nack;
            rxf_q <= rx_full;
        end
    end

    i2cm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx), .push(tx_we), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    i2cm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx), .push(rx_push), .wdata(rx_data),
        .pop(rx_re), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty));

    i2cm_engine u_eng (
        .clk(clk), .rst(rst), .bus_rst(bus_reset),
        .start_req(ctrl_we && cw.master && cw.start),
        .stop_req(ctrl_we && cw.master && cw.stop),
        .nack_force(nack_q), .rbc_we(rbc_we), .rbc_val(rbc_wdata),
        .half_cycles(half_cycles), .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .dev_busy(dev_busy), .bus_busy(bus_busy),
        .stop_seen(stop_seen), .ev_txw(ev.tx_wait), .ev_stop(ev.stop_done),
        .ev_cnt(ev.count_done), .ev_nack(ev.nack), .ev_arb(ev.arb_lost));

    assign ev.rx_full = rx_full && !rxf_q;
    assign events     = ev;
    assign status     = pack_status(dev_busy, stop_seen, bus_busy, rx_full, !rx_empty,
                                    !tx_full, tx_empty);
endmodule

// File: tb/test_fifo_i2c_master.sv
module test_fifo_i2c_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 0, tx_we = 0, rx_re = 0, rbc_we = 0;
    logic [3:0]  ctrl_wdata = 0;
    logic [8:0]  tx_wdata = 0;
    logic [7:0]  rbc_wdata = 0, rx_rdata;
    logic        flush_tx = 0, flush_rx = 0, bus_reset = 0;
    logic [15:0] half_cycles = 16'd4;
    logic        sda_in, scl_oe, sda_oe;
    logic [12:0] status;
    logic [5:0]  events, seen;
    logic        clr_seen = 0, pull = 0, tgt_low;
    int          nerr = 0, nchk = 0;

    localparam logic [6:0] TGT = 7'h50;
    localparam logic [8:0] WR_CMD = {1'b1, TGT, 1'b0};
    localparam logic [8:0] RD_CMD = {1'b1, TGT, 1'b1};
    // table: {read, byte count}
    localparam logic [4:0] CASES [4] = '{5'b0_0001, 5'b0_0011, 5'b1_0001, 5'b1_1000};

    always #5 clk = ~clk;

    wire scl_l = ~scl_oe;
    wire sda_l = ~(sda_oe | tgt_low | pull);
    assign sda_in = sda_l;

    fifo_i2c_master i_fifo_i2c_master (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .rbc_we(rbc_we), .rbc_wdata(rbc_wdata), .flush_tx(flush_tx), .flush_rx(flush_rx),
        .bus_reset(bus_reset), .half_cycles(half_cycles), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .events(events));

    always @(posedge clk) seen <= (rst || clr_seen) ? 6'b0 : (seen | events);

    // target model at address TGT
    logic       p_scl, p_sda, active, is_addr, rdm, macked;
    logic [3:0] bitc;
    logic [7:0] tsh, osh, ridx;
    logic [7:0] wlog [64];
    int         wcnt;

    always @(posedge clk) begin
        p_scl <= scl_l;
        p_sda <= sda_l;
        if (rst) begin
            active <= 0; tgt_low <= 0; bitc <= 0; is_addr <= 0; rdm <= 0;
            macked <= 0; ridx <= 0; wcnt <= 0; tsh <= 0; osh <= 0;
        end else if (p_scl && scl_l && p_sda && !sda_l) begin
            active <= 1; is_addr <= 1; bitc <= 0; tgt_low <= 0;
        end else if (p_scl && scl_l && !p_sda && sda_l) begin
            active <= 0; tgt_low <= 0;
        end else if (active && !p_scl && scl_l) begin
            if (bitc < 8) tsh <= {tsh[6:0], sda_l};
            else          macked <= !sda_l;
            bitc <= bitc + 1;
        end else if (active && p_scl && !scl_l) begin
            if (bitc == 8) begin
                if (is_addr) begin
                    if (tsh[7:1] == TGT) begin tgt_low <= 1; rdm <= tsh[0]; ridx <= 0; end
                    else begin tgt_low <= 0; active <= 0; end
                end else if (!rdm) begin
                    wlog[wcnt[5:0]] <= tsh; wcnt <= wcnt + 1; tgt_low <= 1;
                end else tgt_low <= 0;
            end else if (bitc == 9) begin
                bitc <= 0; is_addr <= 0;
                if (rdm && (is_addr || macked)) begin
                    osh <= 8'hC0 + ridx; tgt_low <= !((8'hC0 + ridx) >> 7); ridx <= ridx + 1;
                end else tgt_low <= 0;
            end else if (rdm && !is_addr) tgt_low <= !osh[7 - bitc];
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic push(input logic [8:0] w);
        @(negedge clk); tx_we = 1; tx_wdata = w;
        @(negedge clk); tx_we = 0;
    endtask

    task automatic ctrl(input logic [3:0] c);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = c;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic set_count(input logic [7:0] v);
        @(negedge clk); rbc_we = 1; rbc_wdata = v;
        @(negedge clk); rbc_we = 0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); d = rx_rdata; rx_re = 1;
        @(negedge clk); rx_re = 0;
    endtask

    task automatic clear_seen();
        @(negedge clk); clr_seen = 1;
        @(negedge clk); clr_seen = 0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!status[12]) break;
        end
        @(negedge clk);
    endtask

    task automatic wait_ev(input int idx);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (seen[idx]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        logic [7:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 status", status, 13'h0003);
        check("R1 lines", {scl_oe, sda_oe}, 0);
        check("R1 events", events, 0);

        // table-driven transfers
        for (int i = 0; i < 4; i++) begin
            logic rd;
            int   n;
            rd = CASES[i][4];
            n  = CASES[i][3:0];
            clear_seen();
            base = wcnt;
            if (!rd) begin
                push(WR_CMD);
                for (int j = 0; j < n; j++) push(9'(8'h30 + i * 8 + j));
                ctrl(4'b1110);
                wait_done();
                check("R3 write count", wcnt - base, n);
                for (int j = 0; j < n; j++)
                    check("R3 write byte", wlog[base + j], 8'h30 + i * 8 + j);
            end else begin
                set_count(8'(n));
                push(RD_CMD);
                ctrl(4'b1110);
                wait_done();
                if (n == 8) begin
                    check("R2 rx full event", seen[1], 1);
                    check("R11 rx full flag", status[3], 1);
                end
                for (int j = 0; j < n; j++) begin
                    pop(d);
                    check("R3 read byte", d, 8'hC0 + j);
                end
                check("R5 count done", seen[3], 1);
            end
            check("R4 stop event", seen[2], 1);
            check("R11 status idle", status, 13'h0803);
        end

        // R2 full FIFO: address + 7 data, ninth push dropped
        base = wcnt;
        push(WR_CMD);
        for (int j = 1; j < 8; j++) push(9'(j));
        push(9'h099);
        check("R2 tx full flag", status[1:0], 2'b00);
        ctrl(4'b1110);
        wait_done();
        check("R2 seven data bytes", wcnt - base, 7);
        check("R2 last byte", wlog[base + 6], 8'h07);

        // R4 START without master bit does nothing
        push(WR_CMD);
        ctrl(4'b0110);
        repeat (20) @(negedge clk);
        check("R4 no master no start", {status[12], scl_oe, sda_oe}, 0);
        @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;

        // R6 manual NACK
        clear_seen();
        set_count(8'd0);
        push(RD_CMD);
        ctrl(4'b1111);
        wait_done();
        pop(d);
        check("R6 manual byte", d, 8'hC0);
        check("R6 single byte only", status[2], 0);
        check("R6 no count event", seen[3], 0);
        ctrl(4'b1000);

        // R7 repeated START
        clear_seen();
        base = wcnt;
        push(WR_CMD);
        push(9'h011);
        ctrl(4'b1100);
        wait_ev(0);
        @(negedge clk);
        check("R13 tx wait event", seen[0], 1);
        check("R13 scl held", scl_oe, 1);
        check("R11 bus busy", status[8], 1);
        set_count(8'd2);
        push(RD_CMD);
        ctrl(4'b1010);
        wait_done();
        check("R7 write part", wlog[base], 8'h11);
        pop(d); check("R7 read 0", d, 8'hC0);
        pop(d); check("R7 read 1", d, 8'hC1);
        check("R5 count after restart", seen[3], 1);

        // R8 address NACK
        clear_seen();
        base = wcnt;
        push({1'b1, 7'h33, 1'b0});
        push(9'h055);
        ctrl(4'b1110);
        wait_done();
        check("R8 nack event", seen[4], 1);
        check("R8 stop still sent", seen[2], 1);
        check("R8 nothing written", wcnt - base, 0);
        check("R8 data left", status[0], 0);
        @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;
        check("R10 tx flushed", status[1:0], 2'b11);

        // R9 empty receive read
        check("R9 empty read zero", rx_rdata, 0);
        pop(d);
        check("R9 empty pop", {status[2], rx_rdata}, 0);

        // R10 receive flush
        set_count(8'd2);
        push(RD_CMD);
        ctrl(4'b1110);
        wait_done();
        check("R10 rx filled", status[2], 1);
        @(negedge clk); flush_rx = 1; @(negedge clk); flush_rx = 0;
        check("R10 rx flushed", {status[2], rx_rdata}, 0);

        // R12 arbitration lost
        clear_seen();
        pull = 1;
        push(WR_CMD);
        ctrl(4'b1100);
        wait_ev(5);
        @(negedge clk);
        check("R12 arb event", seen[5], 1);
        check("R12 lines released", {scl_oe, sda_oe}, 0);
        check("R12 bus free", status[8], 0);
        pull = 0;
        @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;

        // R10 bus reset mid transfer
        push(WR_CMD);
        push(9'h077);
        ctrl(4'b1110);
        repeat (30) @(negedge clk);
        check("R10 busy before reset", status[8], 1);
        @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0;
        check("R10 lines after reset", {scl_oe, sda_oe}, 0);
        check("R10 idle after reset", {status[12], status[8]}, 0);

        report();
    end
endmodule